// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns a single asynchronous serial input line into characters. It counts a 16x oversampling tick to time each bit. A falling edge is taken as a possible start bit, and the block confirms it half a bit period later. It then samples every data, parity and stop bit at the centre of its bit period. Each finished character goes into a one-entry receive buffer, and a buffer-full flag tells the reader that a character is waiting.

Three error flags record what went wrong in reception: parity mismatch, missing stop bit, and a character that arrived while the buffer was still unread. The flags are sticky. Only hardware sets them. Software clears a flag by writing 0 to it, and writing 1 leaves the flag as it is. Clearing the power bit or the receive-enable bit puts the receiver back in its initial state and forces the flags and the buffer-full flag to 0.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rx_data_o`, `rx_full_o` and `status_o` are all zero.
- R2: A character is a low start bit followed by data bits, least significant bit first, then an optional parity bit and a stop bit. Each bit lasts 16 ticks of `tick_i`. The start bit is confirmed 8 ticks after the falling edge, and every later bit is sampled 16 ticks after the previous sample. With `len8_i`=1 the block receives 8 data bits.
- R3: With `len8_i`=0 the block receives 7 data bits, and bit 7 of `rx_data_o` reads 0.
- R4: `par_sel_i` selects the parity mode: 00 = no parity bit, 01 = parity bit present but not checked, 10 = odd, 11 = even. In mode 10 or 11 a parity bit that does not match the received data sets `status_o[1]`.
- R5: In mode 00 or 01 the block never sets `status_o[1]`, whatever value the parity position holds.
- R6: A low first stop bit sets `status_o[0]`. The character is still loaded into the buffer. When `two_stop_i`=1, the block does not check the second stop bit.
- R7: After a framing error the receiver ignores the line until the line has gone high. A line held low after a bad stop bit does not produce a new character.
- R8: A character that completes while `rx_full_o`=1 and `rd_i`=0 sets `status_o[2]` and is discarded, and `rx_data_o` keeps the older character. Any parity or framing error in the discarded character still sets its flag.
- R9: Loading a character sets `rx_full_o`. A one-cycle `rd_i` pulse clears it.
- R10: A write with `st_wr_i`=1 clears each flag whose bit in `st_wdata_i` is 0 and leaves each flag whose bit is 1 unchanged. Software can never set a flag.
- R11: If hardware sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R12: While `pwr_i`=0 or `rx_en_i`=0, `status_o` and `rx_full_o` are 0 and no character is received.
- R13: A low pulse on the line that does not last until the mid-start check is dropped, and no character results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line (idle high) |
| tick_i | input | 1 | One-cycle oversampling strobe, 16 per bit |
| pwr_i | input | 1 | Power control bit |
| rx_en_i | input | 1 | Receive enable bit |
| par_sel_i | input | 2 | Parity mode select |
| two_stop_i | input | 1 | 1 = two stop bits per character |
| len8_i | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| rd_i | input | 1 | Buffer read strobe |
| st_wr_i | input | 1 | Status register write strobe |
| st_wdata_i | input | 3 | Status write data (0 clears a flag) |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_full_o | output | 1 | Buffer holds an unread character |
| status_o | output | 3 | Bit 2 overrun, bit 1 parity error, bit 0 framing error |

## Verification
The assertions assume that `tick_i` is a single-cycle strobe and that the control inputs stay constant while a character is on the line. The line is also taken to change no faster than one bit per 16 ticks, except for the deliberate short glitch. The bench changes the configuration only between characters, with the line idle. It generates the tick from a divider that it never alters in the middle of a character. Stop-bit, parity and break faults are placed at bit boundaries, so every sample lands well inside a stable bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    S_WAITHI,
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_STOP2
  } rx_state_e;

  typedef struct packed {
    logic ovr;
    logic par;
    logic frm;
  } rx_flags_t;

  localparam int FLAG_W = 3;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic [1:0]    par_sel_i,
  input  logic          two_stop_i,
  input  logic          len8_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] MID_T  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;
  logic [DW-1:0] shreg_q;
  logic          pbit_q;
  logic          at_end;

  // two-flop synchroniser, idle level is high
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_i};
  end
  assign rx_s = sync_q[1];

  assign last_idx = len8_i ? IW'(DW - 1) : IW'(DW - 2);
  assign at_end   = (cnt_q == LAST_T);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state_q <= S_WAITHI;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_o  <= 1'b0;
      if (rst) begin
        data_o  <= '0;
        perr_o  <= 1'b0;
        ferr_o  <= 1'b0;
        shreg_q <= '0;
        pbit_q  <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (state_q)
          S_WAITHI: if (rx_s) state_q <= S_IDLE;
          S_IDLE: begin
            if (!rx_s) begin
              state_q <= S_START;
              cnt_q   <= '0;
            end
          end
          S_START: begin
            if (cnt_q == MID_T) begin
              cnt_q <= '0;
              if (rx_s) begin
                state_q <= S_IDLE;
              end else begin
                state_q <= S_DATA;
                idx_q   <= '0;
                shreg_q <= '0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_DATA: begin
            if (at_end) begin
              cnt_q          <= '0;
              shreg_q[idx_q] <= rx_s;
              idx_q          <= idx_q + 1'b1;
              if (idx_q == last_idx)
                state_q <= (par_sel_i == 2'b00) ? S_STOP : S_PAR;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_PAR: begin
            if (at_end) begin
              cnt_q   <= '0;
              pbit_q  <= rx_s;
              state_q <= S_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_STOP: begin
            if (at_end) begin
              cnt_q   <= '0;
              done_o  <= 1'b1;
              data_o  <= shreg_q;
              ferr_o  <= !rx_s;
              perr_o  <= par_sel_i[1] & (^shreg_q ^ pbit_q ^ ~par_sel_i[0]);
              state_q <= (!rx_s || !two_stop_i) ? S_WAITHI : S_STOP2;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          S_STOP2: begin
            if (at_end) begin
              cnt_q   <= '0;
              state_q <= S_WAITHI;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= S_WAITHI;
        endcase
      end
    end
  end

  // R2: completion is a single-cycle event
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: no parity error in modes 00 and 01
  a_r5_no_par_err: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i && state_q == S_STOP && at_end && !par_sel_i[1]) |=> !perr_o);

  // R7: a low line while waiting for high never starts a character
  a_r7_wait_high: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAITHI && !rx_s) |=> (state_q != S_START));

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [DW-1:0]     data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [DW-1:0]     data_o,
  output logic              full_o,
  output logic [FLAG_W-1:0] flags_o
);

  rx_flags_t         flags_q;
  rx_flags_t         set_v;
  logic [FLAG_W-1:0] keep_v;
  logic [DW-1:0]     data_q;
  logic              full_q;
  logic              room;
  logic              load;

  assign room   = !full_q || rd_i;
  assign load   = done_i && room;
  assign set_v  = '{ovr: done_i && !room, par: done_i && perr_i, frm: done_i && ferr_i};
  assign keep_v = wr_i ? wdata_i : {FLAG_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      flags_q <= '0;
    end else if (!en_i) begin
      full_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      if (load) data_q <= data_i;
      full_q  <= load || (full_q && !rd_i);
      flags_q <= (flags_q & keep_v) | set_v;
    end
  end

  assign data_o  = data_q;
  assign full_o  = full_q;
  assign flags_o = flags_q;

  // R12: disabled receiver shows clear flags and empty buffer
  a_r12_off_clears: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (flags_q == '0 && !full_q));

  // R8: overrun keeps the old character and raises the flag
  a_r8_keep_old: assert property (@(posedge clk) disable iff (rst)
    (en_i && done_i && full_q && !rd_i) |=> ($stable(data_q) && flags_q.ovr));

  // R10: software writes never raise a flag
  a_r10_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !done_i) |=> ((flags_q & ~$past(flags_q)) == '0));

  // R9: a completed character always leaves the buffer full
  a_r9_load_sets_full: assert property (@(posedge clk) disable iff (rst)
    (en_i && done_i) |=> full_q);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          pwr_i,
  input  logic          rx_en_i,
  input  logic [1:0]    par_sel_i,
  input  logic          two_stop_i,
  input  logic          len8_i,
  input  logic          rd_i,
  input  logic          st_wr_i,
  input  logic [2:0]    st_wdata_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic [2:0]    status_o
);

  logic          en;
  logic          done;
  logic [DW-1:0] chr;
  logic          perr;
  logic          ferr;

  assign en = pwr_i && rx_en_i;

  uart_rx_sampler #(.OVS(OVS), .DW(DW)) u_smp (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en),
    .rx_i      (rx_i),
    .tick_i    (tick_i),
    .par_sel_i (par_sel_i),
    .two_stop_i(two_stop_i),
    .len8_i    (len8_i),
    .done_o    (done),
    .data_o    (chr),
    .perr_o    (perr),
    .ferr_o    (ferr)
  );

  uart_rx_store #(.DW(DW)) u_st (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en),
    .done_i (done),
    .data_i (chr),
    .perr_i (perr),
    .ferr_i (ferr),
    .rd_i   (rd_i),
    .wr_i   (st_wr_i),
    .wdata_i(st_wdata_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .flags_o(status_o)
  );

endmodule

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;

  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       pwr = 1'b0;
  logic       rxen = 1'b0;
  logic [1:0] psel = 2'b00;
  logic       st2 = 1'b0;
  logic       l8 = 1'b1;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] wd = 3'b000;
  logic [7:0] dout;
  logic       full;
  logic [2:0] stat;

  int div = 1;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_all = 1'b0;

  always #10 clk = ~clk;

  uart_rx_status #(.OVS(OVS), .DW(8)) u0 (
    .clk(clk), .rst(rst), .rx_i(rx), .tick_i(tick), .pwr_i(pwr), .rx_en_i(rxen),
    .par_sel_i(psel), .two_stop_i(st2), .len8_i(l8), .rd_i(rd), .st_wr_i(wr),
    .st_wdata_i(wd), .rx_data_o(dout), .rx_full_o(full), .status_o(stat)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c >= div - 1);
      c = (c >= div - 1) ? 0 : c + 1;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done_all) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rx = v;
    repeat (OVS * div) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic len8, input logic [1:0] pm,
                           input logic badp, input logic stopv, input logic two,
                           input logic stop2v, input int brk);
    logic [7:0] dm;
    logic p;
    l8 = len8; psel = pm; st2 = two;
    dm = len8 ? d : (d & 8'h7F);
    send_bit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) send_bit(d[i]);
    if (pm != 2'b00) begin
      p = (pm == 2'b01) ? 1'b0 : ((pm == 2'b10) ? ~^dm : ^dm);
      send_bit(p ^ badp);
    end
    send_bit(stopv);
    if (two) send_bit(stop2v);
    for (int i = 0; i < brk; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic write_st(input logic [2:0] v);
    wr = 1'b1; wd = v; @(negedge clk); wr = 1'b0; @(negedge clk);
  endtask

  task automatic consume();
    pulse_rd();
    write_st(3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    check("R1 data", dout, 0);
    check("R1 full", full, 0);
    check("R1 status", stat, 0);
    pwr = 1'b1; rxen = 1'b1;
    repeat (4) @(negedge clk);

    // R2: every 8-bit value, no parity
    for (int v = 0; v < 256; v++) begin
      send_char(8'(v), 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 0);
      check("R2 data", dout, v);
      check("R2 status", stat, 0);
      consume();
    end

    // R3: every 7-bit value, even parity, bit 7 sent as 1 must read 0
    for (int v = 0; v < 128; v++) begin
      send_char(8'(v | 8'h80), 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 0);
      check("R3 data", dout, v);
      check("R3 status", stat, 0);
      consume();
    end

    // R4: odd and even parity, good and bad
    for (int m = 2; m < 4; m++) begin
      for (int k = 0; k < 8; k++) begin
        send_char(8'(k * 37 + 5), 1'b1, 2'(m), 1'b0, 1'b1, 1'b0, 1'b1, 0);
        check("R4 good par status", stat, 0);
        consume();
        send_char(8'(k * 37 + 5), 1'b1, 2'(m), 1'b1, 1'b1, 1'b0, 1'b1, 0);
        check("R4 bad par status", stat, 3'b010);
        check("R4 bad par data", dout, (k * 37 + 5) & 255);
        consume();
      end
    end

    // R5: modes 00 and 01 never flag parity
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 4; k++) begin
        send_char(8'(k * 71 + 3), 1'b1, 2'(m), 1'b1, 1'b1, 1'b0, 1'b1, 0);
        check("R5 status", stat, 0);
        check("R5 data", dout, (k * 71 + 3) & 255);
        consume();
      end
    end

    // R6: bad first stop, bad second stop
    send_char(8'hA5, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    check("R6 frm status", stat, 3'b001);
    check("R6 frm data", dout, 8'hA5);
    consume();
    send_char(8'h3C, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    check("R6 second stop ignored", stat, 0);
    check("R6 second stop data", dout, 8'h3C);
    consume();
    check("R6 no extra char", full, 0);
    send_char(8'h5A, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    check("R6 first of two stops", stat, 3'b001);
    consume();

    // R7: break after framing error yields no second character
    send_char(8'h81, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 3);
    check("R7 status", stat, 3'b001);
    check("R7 data", dout, 8'h81);
    consume();
    check("R7 full", full, 0);
    send_char(8'h42, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    check("R7 recovery data", dout, 8'h42);
    check("R7 recovery status", stat, 0);
    consume();

    // R8 and R9: overrun keeps the older character
    send_char(8'h11, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    check("R9 full after load", full, 1);
    send_char(8'h22, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    check("R8 data kept", dout, 8'h11);
    check("R8 status", stat, 3'b100);
    pulse_rd();
    check("R9 full after read", full, 0);
    write_st(3'b000);

    // R10: write-one keeps, write-zero clears
    send_char(8'h66, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    send_char(8'h77, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 0);
    check("R8 all flags", stat, 3'b111);
    check("R8 old data", dout, 8'h66);
    write_st(3'b111);
    check("R10 write ones", stat, 3'b111);
    write_st(3'b101);
    check("R10 clear parity", stat, 3'b101);
    write_st(3'b011);
    check("R10 clear overrun", stat, 3'b001);
    write_st(3'b000);
    check("R10 clear all", stat, 0);
    pulse_rd();

    // R11: set wins over a simultaneous software clear
    fork
      send_char(8'h39, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 0);
      begin
        wr = 1'b1; wd = 3'b000;
        while (!full) @(negedge clk);
        wr = 1'b0;
      end
    join
    check("R11 status", stat, 3'b010);
    consume();

    // R12: disable forces flags and full low, blocks reception
    send_char(8'h10, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 0);
    check("R12 flags before", stat, 3'b011);
    rxen = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 rx_en status", stat, 0);
    check("R12 rx_en full", full, 0);
    send_char(8'h55, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    check("R12 no rx while off", full, 0);
    rxen = 1'b1;
    send_char(8'h20, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    check("R12 flag before pwr off", stat, 3'b001);
    pwr = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 pwr status", stat, 0);
    check("R12 pwr full", full, 0);
    pwr = 1'b1;
    repeat (4) @(negedge clk);
    send_char(8'hC3, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    check("R12 back on data", dout, 8'hC3);
    consume();

    // R13: short glitch rejected
    rx = 1'b0;
    repeat (5) @(negedge clk);
    rx = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    check("R13 glitch", full, 0);

    // R2: slower tick divider
    div = 3;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      send_char(8'(k * 53 + 9), 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 0);
      check("R2 div3 data", dout, (k * 53 + 9) & 255);
      check("R2 div3 status", stat, 0);
      consume();
    end

    done_all = 1'b1;
    finish_run();
  end

endmodule